// File: doc/BRIEF.md
# Masked Peripheral Interrupt Aggregator

This block merges a bank of peripheral interrupt sources into a single interrupt request for a processor. Software sees two word registers on a simple synchronous register bus. One is an enable mask with one bit per source. The other is a status register with one bit per source. Most status bits show the present level of their source line. A configurable set of positions, by default bits 10 and 11 (the receive-complete and transmit-complete events of a serial peripheral), instead latch a rising edge of their source and hold it until software writes a 1 to that position.

The pending set is status AND mask. The request output is high while any pending bit is set. Alongside it the block reports the lowest-numbered pending source as a service index with a qualifying valid flag, so a handler can tell a real request from a spurious one.

Reads are combinational: read data follows the address in the same cycle. Writes take effect at the rising clock edge. Reset is synchronous and active high. Source lines are assumed to be synchronous to the block clock.

Top module: `periph_irq_aggr`

## Requirements
- R1: While reset is high at a rising edge, the mask and both sticky status bits are cleared. After that edge `irq_req` and `svc_vld` are 0, `svc_idx` is 0 and the mask reads 0.
- R2: A write to word address 0 stores all 32 bits of write data in the mask at that edge, and address 0 then reads back exactly that value. A mask bit of 1 lets its source through. A mask bit of 0 blocks it.
- R3: Every status bit outside positions 10 and 11 reads, at word address 1, the present level of its source line in the same cycle. Writes to those positions have no effect on the value read.
- R4: Status bit 10 or 11 becomes 1 at a rising edge where its source is 1 and was 0 at the previous edge. A source already high when reset is released counts as new. The bit then holds 1 until it is cleared.
- R5: Writing to address 1 with data bit 10 or 11 set clears that sticky bit at the edge. A 0 in the data leaves the bit unchanged.
- R6: If a new source edge and a clearing write hit the same sticky bit in one cycle, the bit is 1 after the edge.
- R7: `irq_req` is 1 in exactly the cycles where status AND mask is non-zero, with no added latency.
- R8: `svc_idx` is the lowest bit position set in status AND mask, and `svc_vld` is then 1. With nothing pending, `svc_vld` is 0 and `svc_idx` is 0.
- R9: After the start-up sequence (write 0x00000000 to the mask, then 0xFFFFFFFF to the status), no source can raise `irq_req` and both sticky bits read 0.
- R10: Reads from any word address other than 0 or 1 return 0. Writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | 32 | Source lines, one per interrupt source |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address (0 mask, 1 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |
| svc_idx | output | 5 | Lowest pending source index |
| svc_vld | output | 1 | High when `svc_idx` names a pending source |

## Verification
Read data, `irq_req`, `svc_idx` and `svc_vld` depend combinationally on the source lines and on the registered mask and sticky bits. A change in a source level or in the address therefore shows in the same cycle. A mask write, a sticky clear or a sticky set shows only after the rising edge that captures it, so a source rise is visible one edge later. The bench drives every input 1 ns after a rising edge and compares all outputs against its behavioural model at the following falling edge. Every expected value is then settled, including those from state captured at the edge just passed.

// File: rtl/pia_pkg.sv
package pia_pkg;

    // Register word addresses on the bus
    localparam int unsigned PIA_ADDR_MASK = 0;
    localparam int unsigned PIA_ADDR_STAT = 1;

    // Default sticky positions: serial receive-complete (10), transmit-complete (11)
    localparam logic [31:0] PIA_STICKY_DEFAULT = 32'h0000_0C00;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e pia_decode(input logic [31:0] addr);
        if (addr == PIA_ADDR_MASK)      return SEL_MASK;
        else if (addr == PIA_ADDR_STAT) return SEL_STAT;
        else                            return SEL_NONE;
    endfunction

endpackage

// File: rtl/pia_mask_regs.sv
module pia_mask_regs
    import pia_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_op_t         op,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] stat,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (op.wr && op.sel == SEL_MASK) begin
            mask_q <= wdata;
        end
    end

    always_comb begin
        unique case (op.sel)
            SEL_MASK: rdata = mask_q;
            SEL_STAT: rdata = stat;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pia_status.sv
module pia_status #(
    parameter int              NSRC       = 32,
    parameter logic [NSRC-1:0] STICKY_MAP = NSRC'(32'h0000_0C00)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] stat
);

    // clear requests only matter at sticky positions
    logic unused_clr;
    assign unused_clr = ^(clr & ~STICKY_MAP);

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        if (STICKY_MAP[g]) begin : g_sticky
            logic prev_q;
            logic hold_q;
            logic rise;

            assign rise = src[g] & ~prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    hold_q <= 1'b0;
                end else begin
                    prev_q <= src[g];
                    // a fresh edge beats a simultaneous clear
                    hold_q <= rise | (hold_q & ~clr[g]);
                end
            end

            assign stat[g] = hold_q;
        end else begin : g_level
            assign stat[g] = src[g];
        end
    end

endmodule

// File: rtl/pia_prio.sv
module pia_prio #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);

    // lowest set bit wins: scan from the top so lower hits overwrite
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign vld = |pend;

endmodule

// File: rtl/periph_irq_aggr.sv
module periph_irq_aggr
    import pia_pkg::*;
#(
    parameter int              NSRC       = 32,
    parameter int              AW         = 4,
    parameter logic [NSRC-1:0] STICKY_MAP = PIA_STICKY_DEFAULT,
    localparam int             IDX_W      = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_lvl,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    output logic             irq_req,
    output logic [IDX_W-1:0] svc_idx,
    output logic             svc_vld
);

    bus_op_t         op;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] stat_w;
    logic [NSRC-1:0] clr_w;
    logic [NSRC-1:0] pend_w;

    assign op.wr  = bus_wr;
    assign op.sel = pia_decode(32'(bus_addr));

    assign clr_w = (bus_wr && op.sel == SEL_STAT) ? (bus_wdata & STICKY_MAP) : '0;

    pia_status #(
        .NSRC       (NSRC),
        .STICKY_MAP (STICKY_MAP)
    ) u_status (
        .clk  (clk),
        .rst  (rst),
        .src  (src_lvl),
        .clr  (clr_w),
        .stat (stat_w)
    );

    pia_mask_regs #(
        .NSRC (NSRC)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wdata  (bus_wdata),
        .stat   (stat_w),
        .mask_q (mask_q),
        .rdata  (bus_rdata)
    );

    assign pend_w  = stat_w & mask_q;
    assign irq_req = |pend_w;

    pia_prio #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W)
    ) u_prio (
        .pend (pend_w),
        .idx  (svc_idx),
        .vld  (svc_vld)
    );

endmodule

// File: rtl/pia_checker.sv
module pia_checker #(
    parameter int              NSRC       = 32,
    parameter int              AW         = 4,
    parameter logic [NSRC-1:0] STICKY_MAP = NSRC'(32'h0000_0C00),
    parameter int              IDX_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [NSRC-1:0]  src_lvl,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [NSRC-1:0]  bus_wdata,
    input logic [NSRC-1:0]  bus_rdata,
    input logic             irq_req,
    input logic [IDX_W-1:0] svc_idx,
    input logic             svc_vld,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  stat_w
);

    logic [NSRC-1:0] pend;
    assign pend = stat_w & mask_q;

    // R1: reset clears the mask
    assert_reset_mask_R1: assert property (@(posedge clk)
        rst |=> (mask_q == '0));

    // R2: a mask write is stored
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'(0)) |=> (mask_q == $past(bus_wdata)));

    // R3: level positions read the source
    assert_level_read_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(1)) |-> ((bus_rdata & ~STICKY_MAP) == (src_lvl & ~STICKY_MAP)));

    // R7: request and valid agree
    assert_irq_match_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req == svc_vld);

    // R8: reported index is pending and nothing lower is
    assert_lowest_idx_R8: assert property (@(posedge clk) disable iff (rst)
        svc_vld |-> (pend[svc_idx] && ((pend & ((NSRC'(1) << svc_idx) - NSRC'(1))) == '0)));

    // R10: unmapped reads return zero
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > AW'(1)) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        if (STICKY_MAP[g]) begin : g_s
            // R4: held without a clear
            assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
                (stat_w[g] && !(bus_wr && bus_addr == AW'(1) && bus_wdata[g])) |=> stat_w[g]);

            // R5: clear takes effect without a new edge
            assert_sticky_clear_R5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && bus_wr && bus_addr == AW'(1) && bus_wdata[g]
                 && !(src_lvl[g] && !$past(src_lvl[g]))) |=> !stat_w[g]);

            // R6: an edge sets the bit even under a clear
            assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
                (src_lvl[g] && !$past(src_lvl[g])) |=> stat_w[g]);
        end
    end

endmodule

bind periph_irq_aggr pia_checker #(
    .NSRC       (NSRC),
    .AW         (AW),
    .STICKY_MAP (STICKY_MAP),
    .IDX_W      (IDX_W)
) u_pia_chk (
    .clk       (clk),
    .rst       (rst),
    .src_lvl   (src_lvl),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .svc_idx   (svc_idx),
    .svc_vld   (svc_vld),
    .mask_q    (mask_q),
    .stat_w    (stat_w)
);

// File: tb/periph_irq_aggr_tb_top.sv
`timescale 1ns/1ps
module periph_irq_aggr_tb_top;

    localparam logic [31:0] SMAP = 32'h0000_0C00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [4:0]  svc_idx;
    logic        svc_vld;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_mask = '0;
    logic [31:0] m_stk  = '0;
    logic [31:0] m_prev = '0;

    always #5 clk = ~clk;

    periph_irq_aggr dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_lvl   (src_lvl),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .svc_idx   (svc_idx),
        .svc_vld   (svc_vld)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // model update at each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_mask = '0;
            m_stk  = '0;
            m_prev = '0;
        end else begin
            logic [31:0] clrv;
            clrv = (bus_wr && bus_addr == 4'd1) ? (bus_wdata & SMAP) : '0;
            m_stk = (m_stk & ~clrv) | (src_lvl & ~m_prev & SMAP);
            if (bus_wr && bus_addr == 4'd0) m_mask = bus_wdata;
            m_prev = src_lvl;
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] st, pd, rd;
            int lo;
            st = (src_lvl & ~SMAP) | m_stk;
            pd = st & m_mask;
            lo = 0;
            for (int i = 31; i >= 0; i--) if (pd[i]) lo = i;
            rd = (bus_addr == 4'd0) ? m_mask : (bus_addr == 4'd1) ? st : 32'd0;
            check(irq_req == (pd != 0), "R7 irq_req", 32'(irq_req), 32'(pd != 0));
            check(svc_vld == (pd != 0), "R8 svc_vld", 32'(svc_vld), 32'(pd != 0));
            check(svc_idx == 5'(lo), "R8 svc_idx", 32'(svc_idx), 32'(lo));
            check(bus_rdata == rd, "R2/R3/R10 bus_rdata", bus_rdata, rd);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        check(bus_rdata == exp, tag, bus_rdata, exp);
        tick();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        check(irq_req == 1'b0, "R1 irq after reset", 32'(irq_req), 0);
        check(svc_vld == 1'b0 && svc_idx == 0, "R1 svc after reset", {26'd0, svc_vld, svc_idx}, 0);
        tick();
        read_chk(4'd0, 32'h0, "R1 mask after reset");

        // R4: sticky events latch
        src_lvl = 32'h0000_0C00;
        tick();
        src_lvl = '0;
        tick();
        read_chk(4'd1, 32'h0000_0C00, "R4 sticky bits held");

        // R9: start-up sequence
        bus_write(4'd0, 32'h0000_0000);
        bus_write(4'd1, 32'hFFFF_FFFF);
        src_lvl = 32'h0000_F0F0;
        read_chk(4'd1, 32'h0000_F0F0, "R9 sticky cleared");
        check(irq_req == 1'b0, "R9 no request with mask zero", 32'(irq_req), 0);

        // R2: mask readback
        bus_write(4'd0, 32'hA5A5_3C0F);
        read_chk(4'd0, 32'hA5A5_3C0F, "R2 mask readback");

        // R7/R8: level sources through mask
        bus_write(4'd0, 32'hFFFF_FFFF);
        src_lvl = 32'h0000_0100;
        @(negedge clk);
        check(svc_idx == 5'd8 && svc_vld, "R8 single source idx", 32'(svc_idx), 8);
        tick();
        src_lvl = 32'h8000_0020;
        @(negedge clk);
        check(svc_idx == 5'd5, "R8 lowest of two", 32'(svc_idx), 5);
        tick();
        bus_write(4'd0, 32'hFFFF_FFDF);
        @(negedge clk);
        check(svc_idx == 5'd31 && irq_req, "R2 masked bit blocked", 32'(svc_idx), 31);
        tick();

        // R3: writes to level positions ignored
        src_lvl = 32'h0000_0050;
        bus_write(4'd1, 32'hFFFF_F3FF);
        read_chk(4'd1, 32'h0000_0050, "R3 level write ignored");

        // R5: zero data leaves sticky, one clears
        src_lvl = 32'h0000_0400;
        tick();
        src_lvl = '0;
        bus_write(4'd1, 32'h0000_0800);
        read_chk(4'd1, 32'h0000_0400, "R5 zero leaves bit10");
        bus_write(4'd1, 32'h0000_0400);
        read_chk(4'd1, 32'h0000_0000, "R5 clear bit10");

        // R6: set wins over clear in the same cycle
        src_lvl = 32'h0000_0400;
        bus_write(4'd1, 32'h0000_0400);
        src_lvl = '0;
        read_chk(4'd1, 32'h0000_0400, "R6 set beats clear");
        bus_write(4'd1, 32'h0000_0C00);

        // R10: unmapped address
        bus_write(4'd0, 32'h1234_5678);
        bus_write(4'd5, 32'hFFFF_FFFF);
        read_chk(4'd5, 32'h0, "R10 unmapped read");
        read_chk(4'd0, 32'h1234_5678, "R10 mask untouched");

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            src_lvl   = $urandom & $urandom;
            bus_wr    = (r[3:0] < 4'd3);
            bus_addr  = (r[7:4] < 4'd6) ? 4'd0 : (r[7:4] < 4'd13) ? 4'd1 : 4'(r[11:8]);
            bus_wdata = r[12] ? $urandom : ($urandom & $urandom & $urandom);
            tick();
        end
        bus_wr = 1'b0;
        tick();

        // R1: reset again mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        src_lvl = '0;
        bus_addr = 4'd0;
        @(negedge clk);
        check(bus_rdata == 0 && !irq_req, "R1 reset mid-run", bus_rdata, 0);
        tick();
        finish_run();
    end

endmodule